// File: doc/BRIEF.md
# Steering target resolver

This block maps a register address to the group and instance identifiers that steer an access toward a copy of a replicated register that is present in silicon. Each address is compared against per-class lists of inclusive address ranges. The classes are checked in a fixed priority order, and the first class with a matching range selects the rule that produces the pair.

The rules take the lowest enabled bank, the lowest enabled memory slice or the first enabled sub-slice from enable masks supplied at the ports. Some classes use a fixed pair instead. When no class matches, the block returns a default pair supplied by the caller and clears the explicit-steering flag. The range tables and their entry counts are elaboration parameters. The result is registered one cycle after a valid address.

Top module: `steer_resolver`

## Requirements
- R1: An address matches a range when start <= address <= end, with both bounds inclusive; one above the end does not match.
- R2: Classes are checked in the order bank (0), memory slice (1), node (2), memory access (3), sub-slice (4), instance zero (5), and the first matching class sets the result.
- R3: When no class matches, group_o and inst_o equal the default pair given with the address, and explicit_o is 0; any match sets explicit_o to 1.
- R4: For the bank class, group is 0 and instance is the lowest set bit index of the bank mask; fuse bit i of bank_fuse_i enables banks 2i and 2i+1.
- R5: For the memory-slice class, group is the lowest set bit index of slice_mask_i and instance is 0.
- R6: For the node class, group is twice the lowest set slice index and instance is 0.
- R7: For the memory-access class, group is the parameter MEM_ACCESS_GROUP (default 1) and instance is 0.
- R8: For the sub-slice class, with n the lowest set bit index of subslice_mask_i, group is n / SS_PER_GROUP and instance is n % SS_PER_GROUP.
- R9: For the instance-zero class, group and instance are both 0, with no error.
- R10: A class with an entry count of 0 never matches, and table slots at or above a class's count are ignored.
- R11: When the selected class derives its pair from an enable mask that is all zero, the index used is 0 and error_o is 1; otherwise error_o is 0.
- R12: Outputs load on the clock edge where addr_valid_i is 1, and valid_o is addr_valid_i delayed by one cycle. All other outputs hold their values while addr_valid_i is 0.
- R13: After reset, valid_o, group_o, inst_o, explicit_o and error_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Address qualifier |
| addr_i | input | ADDR_W (24) | Register address to classify |
| bank_fuse_i | input | BANK_FUSE_W | Bank-pair enables, one bit per two banks |
| slice_mask_i | input | SLICE_W | Memory-slice enable mask |
| subslice_mask_i | input | SUBSLICE_W | Sub-slice enable mask |
| dflt_group_i | input | GROUP_W | Group used when no class matches |
| dflt_inst_i | input | INST_W | Instance used when no class matches |
| valid_o | output | 1 | Result valid, one cycle after addr_valid_i |
| group_o | output | GROUP_W | Steering group |
| inst_o | output | INST_W | Steering instance |
| explicit_o | output | 1 | Address belongs to a steering class |
| error_o | output | 1 | Selected class had an all-zero enable mask |

## Verification
The bench builds two copies. The first uses the default tables, with four bank-fuse bits, four slices, sixteen sub-slices split four per group, and MEM_ACCESS_GROUP of 1. The default tables place ranges that overlap across classes and a populated slot beyond a class's count, so priority and count gating can both be reached. The second copy sets the memory-access count to zero, which lets a class with no ranges be compared against the same address in the first copy.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int ADDR_W     = 24;
  localparam int NUM_CLASS  = 6;
  localparam int MAX_RANGES = 8;
  localparam int CNT_W      = $clog2(MAX_RANGES + 1);

  typedef enum logic [2:0] {
    CLS_BANK     = 3'd0,
    CLS_SLICE    = 3'd1,
    CLS_NODE     = 3'd2,
    CLS_MEMACC   = 3'd3,
    CLS_SUBSLICE = 3'd4,
    CLS_ZERO     = 3'd5,
    CLS_NONE     = 3'd7
  } steer_class_e;

  typedef logic [NUM_CLASS-1:0][MAX_RANGES-1:0][2*ADDR_W-1:0] range_tbl_t;
  typedef logic [NUM_CLASS-1:0][CNT_W-1:0]                     range_cnt_t;

  function automatic logic [2*ADDR_W-1:0] rng(logic [ADDR_W-1:0] lo, logic [ADDR_W-1:0] hi);
    return {lo, hi};
  endfunction

  function automatic range_tbl_t build_tbl();
    range_tbl_t t = '0;
    t[0][0] = rng(24'h00B100, 24'h00B3FF);
    t[1][0] = rng(24'h00DD00, 24'h00DDFF);
    t[1][1] = rng(24'h00E900, 24'h00FFFF);
    t[2][0] = rng(24'h00B000, 24'h00B0FF);
    t[2][1] = rng(24'h00D800, 24'h00D8FF);
    t[3][0] = rng(24'h004000, 24'h004AFF);
    t[3][1] = rng(24'h00C800, 24'h00CFFF);
    t[4][0] = rng(24'h005200, 24'h0052FF);
    t[4][1] = rng(24'h005500, 24'h007FFF);
    t[5][0] = rng(24'h008800, 24'h00887F);
    t[5][1] = rng(24'h00B000, 24'h00B3FF);
    t[5][2] = rng(24'h020000, 24'h02FFFF); // beyond count: inert
    return t;
  endfunction

  function automatic range_cnt_t build_cnt();
    range_cnt_t c;
    c[0] = CNT_W'(1);
    c[1] = CNT_W'(2);
    c[2] = CNT_W'(2);
    c[3] = CNT_W'(2);
    c[4] = CNT_W'(2);
    c[5] = CNT_W'(2);
    return c;
  endfunction

  localparam range_tbl_t DEFAULT_TBL = build_tbl();
  localparam range_cnt_t DEFAULT_CNT = build_cnt();
endpackage

// File: rtl/steer_range_match.sv
module steer_range_match #(
  parameter int AW  = 24,
  parameter int NR  = 8,
  parameter logic [NR-1:0][2*AW-1:0] TBL = '0,
  parameter int CNT = 0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [NR-1:0] slot_hit;

  for (genvar i = 0; i < NR; i++) begin : g_slot
    if (i < CNT) begin : g_on
      localparam logic [AW-1:0] LO = TBL[i][2*AW-1:AW];
      localparam logic [AW-1:0] HI = TBL[i][AW-1:0];
      assign slot_hit[i] = (addr_i >= LO) && (addr_i <= HI);
    end else begin : g_off
      assign slot_hit[i] = 1'b0;
    end
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/steer_first_set.sv
module steer_first_set #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             none_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign none_o = ~|mask_i;
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int         BANK_FUSE_W      = 4,
  parameter int         SLICE_W          = 4,
  parameter int         SUBSLICE_W       = 16,
  parameter int         SS_PER_GROUP     = 4,
  parameter int         GROUP_W          = 8,
  parameter int         INST_W           = 8,
  parameter int         MEM_ACCESS_GROUP = 1,
  parameter range_tbl_t RANGE_TBL        = DEFAULT_TBL,
  parameter range_cnt_t RANGE_CNT        = DEFAULT_CNT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   addr_valid_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BANK_FUSE_W-1:0] bank_fuse_i,
  input  logic [SLICE_W-1:0]     slice_mask_i,
  input  logic [SUBSLICE_W-1:0]  subslice_mask_i,
  input  logic [GROUP_W-1:0]     dflt_group_i,
  input  logic [INST_W-1:0]      dflt_inst_i,
  output logic                   valid_o,
  output logic [GROUP_W-1:0]     group_o,
  output logic [INST_W-1:0]      inst_o,
  output logic                   explicit_o,
  output logic                   error_o
);
  localparam int BANK_W     = 2 * BANK_FUSE_W;
  localparam int BANK_IDX_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;
  localparam int SL_IDX_W   = (SLICE_W > 1) ? $clog2(SLICE_W) : 1;
  localparam int SS_IDX_W   = (SUBSLICE_W > 1) ? $clog2(SUBSLICE_W) : 1;

  // Each fuse bit covers a pair of banks
  logic [BANK_W-1:0] bank_mask;
  for (genvar i = 0; i < BANK_FUSE_W; i++) begin : g_bank_pair
    assign bank_mask[2*i+:2] = {2{bank_fuse_i[i]}};
  end

  logic [NUM_CLASS-1:0] class_hit;
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    steer_range_match #(
      .AW (ADDR_W),
      .NR (MAX_RANGES),
      .TBL(RANGE_TBL[c]),
      .CNT(int'(RANGE_CNT[c]))
    ) i_match (
      .addr_i(addr_i),
      .hit_o (class_hit[c])
    );
  end

  logic [BANK_IDX_W-1:0] bank_idx;
  logic [SL_IDX_W-1:0]   slice_idx;
  logic [SS_IDX_W-1:0]   ss_idx;
  logic                  bank_none, slice_none, ss_none;

  steer_first_set #(.W(BANK_W), .IDX_W(BANK_IDX_W)) i_bank_first (
    .mask_i(bank_mask), .idx_o(bank_idx), .none_o(bank_none)
  );
  steer_first_set #(.W(SLICE_W), .IDX_W(SL_IDX_W)) i_slice_first (
    .mask_i(slice_mask_i), .idx_o(slice_idx), .none_o(slice_none)
  );
  steer_first_set #(.W(SUBSLICE_W), .IDX_W(SS_IDX_W)) i_ss_first (
    .mask_i(subslice_mask_i), .idx_o(ss_idx), .none_o(ss_none)
  );

  // Lowest class index wins
  steer_class_e cls;
  always_comb begin
    cls = CLS_NONE;
    for (int c = NUM_CLASS - 1; c >= 0; c--) begin
      if (class_hit[c]) cls = steer_class_e'(3'(c));
    end
  end

  logic [GROUP_W-1:0] grp_d;
  logic [INST_W-1:0]  inst_d;
  logic               err_d;

  always_comb begin
    grp_d  = '0;
    inst_d = '0;
    err_d  = 1'b0;
    unique case (cls)
      CLS_BANK: begin
        inst_d = INST_W'(bank_idx);
        err_d  = bank_none;
      end
      CLS_SLICE: begin
        grp_d = GROUP_W'(slice_idx);
        err_d = slice_none;
      end
      CLS_NODE: begin
        grp_d = GROUP_W'({slice_idx, 1'b0});
        err_d = slice_none;
      end
      CLS_MEMACC: grp_d = GROUP_W'(MEM_ACCESS_GROUP);
      CLS_SUBSLICE: begin
        grp_d  = GROUP_W'(int'(ss_idx) / SS_PER_GROUP);
        inst_d = INST_W'(int'(ss_idx) % SS_PER_GROUP);
        err_d  = ss_none;
      end
      CLS_ZERO: ;
      default: begin
        grp_d  = dflt_group_i;
        inst_d = dflt_inst_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      group_o    <= '0;
      inst_o     <= '0;
      explicit_o <= 1'b0;
      error_o    <= 1'b0;
    end else begin
      valid_o <= addr_valid_i;
      if (addr_valid_i) begin
        group_o    <= grp_d;
        inst_o     <= inst_d;
        explicit_o <= (cls != CLS_NONE);
        error_o    <= err_d;
      end
    end
  end
endmodule

// File: rtl/steer_resolver_chk.sv
module steer_resolver_chk #(
  parameter int GROUP_W = 8,
  parameter int INST_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               addr_valid_i,
  input logic [GROUP_W-1:0] dflt_group_i,
  input logic [INST_W-1:0]  dflt_inst_i,
  input logic               valid_o,
  input logic [GROUP_W-1:0] group_o,
  input logic [INST_W-1:0]  inst_o,
  input logic               explicit_o,
  input logic               error_o
);
  assert_valid_delay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(addr_valid_i)));

  assert_hold_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> ($stable(group_o) && $stable(inst_o) && $stable(explicit_o) && $stable(error_o)));

  assert_default_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i) |=> (explicit_o || (group_o == $past(dflt_group_i) && inst_o == $past(dflt_inst_i))));

  assert_error_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (explicit_o && group_o == '0 && inst_o == '0));
endmodule

bind steer_resolver steer_resolver_chk #(.GROUP_W(GROUP_W), .INST_W(INST_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_valid_i(addr_valid_i),
  .dflt_group_i(dflt_group_i),
  .dflt_inst_i (dflt_inst_i),
  .valid_o     (valid_o),
  .group_o     (group_o),
  .inst_o      (inst_o),
  .explicit_o  (explicit_o),
  .error_o     (error_o)
);

// File: tb/test_steer_resolver.sv
module test_steer_resolver;
  import steer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_valid = 1'b0;
  logic [23:0] addr = '0;
  logic [3:0]  bank_fuse = '0;
  logic [3:0]  slice_mask = '0;
  logic [15:0] ss_mask = '0;
  logic [7:0]  dflt_group = '0;
  logic [7:0]  dflt_inst = '0;

  logic       valid_o, explicit_o, error_o;
  logic [7:0] group_o, inst_o;
  logic       a_valid, a_explicit, a_error;
  logic [7:0] a_group, a_inst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  steer_resolver i_steer_resolver (
    .clk_i(clk), .rst_ni(rst_ni), .addr_valid_i(addr_valid), .addr_i(addr),
    .bank_fuse_i(bank_fuse), .slice_mask_i(slice_mask), .subslice_mask_i(ss_mask),
    .dflt_group_i(dflt_group), .dflt_inst_i(dflt_inst),
    .valid_o(valid_o), .group_o(group_o), .inst_o(inst_o),
    .explicit_o(explicit_o), .error_o(error_o)
  );

  function automatic range_cnt_t no_memacc_cnt();
    range_cnt_t c = DEFAULT_CNT;
    c[3] = '0;
    return c;
  endfunction

  steer_resolver #(.RANGE_CNT(no_memacc_cnt())) i_steer_resolver_nomem (
    .clk_i(clk), .rst_ni(rst_ni), .addr_valid_i(addr_valid), .addr_i(addr),
    .bank_fuse_i(bank_fuse), .slice_mask_i(slice_mask), .subslice_mask_i(ss_mask),
    .dflt_group_i(dflt_group), .dflt_inst_i(dflt_inst),
    .valid_o(a_valid), .group_o(a_group), .inst_o(a_inst),
    .explicit_o(a_explicit), .error_o(a_error)
  );

  task automatic expect_out(string req, logic v, logic [7:0] g, logic [7:0] i, logic x, logic e);
    checks++;
    if (valid_o !== v || group_o !== g || inst_o !== i || explicit_o !== x || error_o !== e) begin
      errors++;
      $display("FAIL %s: got v=%0b g=%0h i=%0h x=%0b e=%0b, expected v=%0b g=%0h i=%0h x=%0b e=%0b",
               req, valid_o, group_o, inst_o, explicit_o, error_o, v, g, i, x, e);
    end
  endtask

  // drive one address, sample after the registering edge
  task automatic lookup(logic [23:0] a);
    @(negedge clk);
    addr = a;
    addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic test_reset();
    expect_out("R13", 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_bounds();
    lookup(24'h00B100); expect_out("R1 start", 1'b1, 8'h00, 8'h04, 1'b1, 1'b0);
    lookup(24'h00B3FF); expect_out("R1 end", 1'b1, 8'h00, 8'h04, 1'b1, 1'b0);
    lookup(24'h00B400); expect_out("R1 past end", 1'b1, 8'h5A, 8'h3C, 1'b0, 1'b0);
  endtask

  task automatic test_priority();
    lookup(24'h00B200); expect_out("R2 bank over zero", 1'b1, 8'h00, 8'h04, 1'b1, 1'b0);
    lookup(24'h00B0FF); expect_out("R2 node over zero", 1'b1, 8'h02, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic test_default();
    lookup(24'h001234); expect_out("R3", 1'b1, 8'h5A, 8'h3C, 1'b0, 1'b0);
    dflt_group = 8'hC3; dflt_inst = 8'h11;
    lookup(24'h0FFFFF); expect_out("R3 new pair", 1'b1, 8'hC3, 8'h11, 1'b0, 1'b0);
    dflt_group = 8'h5A; dflt_inst = 8'h3C;
  endtask

  task automatic test_bank();
    bank_fuse = 4'b1000;
    lookup(24'h00B180); expect_out("R4 top pair", 1'b1, 8'h00, 8'h06, 1'b1, 1'b0);
    bank_fuse = 4'b1011;
    lookup(24'h00B180); expect_out("R4 low pair", 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    bank_fuse = 4'b0100;
  endtask

  task automatic test_slice();
    lookup(24'h00DD10); expect_out("R5", 1'b1, 8'h01, 8'h00, 1'b1, 1'b0);
    slice_mask = 4'b1000;
    lookup(24'h00F000); expect_out("R5 top", 1'b1, 8'h03, 8'h00, 1'b1, 1'b0);
    lookup(24'h00D810); expect_out("R6 top", 1'b1, 8'h06, 8'h00, 1'b1, 1'b0);
    slice_mask = 4'b0110;
    lookup(24'h00D810); expect_out("R6", 1'b1, 8'h02, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic test_memacc();
    lookup(24'h004100); expect_out("R7", 1'b1, 8'h01, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic test_subslice();
    lookup(24'h006000); expect_out("R8 mid", 1'b1, 8'h02, 8'h01, 1'b1, 1'b0);
    ss_mask = 16'h8000;
    lookup(24'h005200); expect_out("R8 top", 1'b1, 8'h03, 8'h03, 1'b1, 1'b0);
    ss_mask = 16'h0001;
    lookup(24'h007FFF); expect_out("R8 low", 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    ss_mask = 16'h0A00;
  endtask

  task automatic test_zero_class();
    lookup(24'h008840); expect_out("R9", 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic test_count();
    lookup(24'h004100);
    checks++;
    if (a_valid !== 1'b1 || a_group !== 8'h5A || a_inst !== 8'h3C || a_explicit !== 1'b0) begin
      errors++;
      $display("FAIL R10 empty class: got g=%0h i=%0h x=%0b, expected g=5a i=3c x=0",
               a_group, a_inst, a_explicit);
    end
    lookup(24'h021000); expect_out("R10 slot beyond count", 1'b1, 8'h5A, 8'h3C, 1'b0, 1'b0);
  endtask

  task automatic test_empty_mask();
    bank_fuse = 4'b0000;
    lookup(24'h00B200); expect_out("R11 bank", 1'b1, 8'h00, 8'h00, 1'b1, 1'b1);
    bank_fuse = 4'b0100;
    slice_mask = 4'b0000;
    lookup(24'h00D810); expect_out("R11 node", 1'b1, 8'h00, 8'h00, 1'b1, 1'b1);
    slice_mask = 4'b0110;
    ss_mask = 16'h0000;
    lookup(24'h006000); expect_out("R11 subslice", 1'b1, 8'h00, 8'h00, 1'b1, 1'b1);
    ss_mask = 16'h0A00;
    lookup(24'h008840); expect_out("R11 clears", 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic test_hold();
    lookup(24'h006000);
    expect_out("R12 load", 1'b1, 8'h02, 8'h01, 1'b1, 1'b0);
    addr = 24'h001234; ss_mask = 16'h0000; dflt_group = 8'hEE;
    repeat (3) @(negedge clk);
    expect_out("R12 hold", 1'b0, 8'h02, 8'h01, 1'b1, 1'b0);
    ss_mask = 16'h0A00; dflt_group = 8'h5A;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    bank_fuse = 4'b0100; slice_mask = 4'b0110; ss_mask = 16'h0A00;
    dflt_group = 8'h5A; dflt_inst = 8'h3C;
    @(negedge clk);
    test_reset();
    test_bounds();
    test_priority();
    test_default();
    test_bank();
    test_slice();
    test_memacc();
    test_subslice();
    test_zero_class();
    test_count();
    test_empty_mask();
    test_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule